// File: doc/BRIEF.md
# Serial Command and Readout Port for a Display Controller

This block is the host-facing serial slave of a display and key-matrix controller. The host talks to it over a chip-select line, a serial clock and a data line. The data line is split here into an input, an output and an output-enable. While chip-select is high, the port shifts in a frame least significant bit first. The last three bits of every frame form a mode field. When chip-select drops, the port decodes that mode. Depending on the mode, it writes the payload into one or all of the three per-grid segment latches, writes the dimming latch, issues a stop-scan pulse, or arms a readout.

A readout is a two-window exchange. In the first window the host sends a mode-only frame that arms a switch readout or an ADC readout. At the opening of the next chip-select window the port captures the matching snapshot into an output shift register. It then drives the snapshot onto the data line, one bit per rising serial-clock edge. When chip-select falls, the output driver is released and the port returns to receiving frames. The serial inputs are sampled in the block's own clock domain, and all edges are detected there.

Top module: `tri_wire_port`

## Requirements
- R1: After reset, all three segment latches, the dimming latch, `sdOut`, `sdOe` and `scanStop` are zero.
- R2: A bit is captured only on a rising `sclkIn` edge seen while `csIn` is high, and bits arrive least significant first. A rising edge in the same cycle as the chip-select edge that opens or closes the window is ignored. The receive register is cleared when a window opens, so bits that were never received read as zero.
- R3: The mode is formed from the last three bits of a window: the third-from-last bit is mode bit 0 and the last bit is mode bit 2. It is decoded in the cycle the chip-select fall is seen. A window with fewer than three bits changes nothing. The payload is formed from the 32 bits that precede the mode, and the earliest of those bits becomes bit 0.
- R4: Mode 0 writes the payload to all three segment latches. Modes 1, 2 and 3 write only the latch of grid 1, 2 or 3. Grid k occupies `segOut[32k-1:32(k-1)]`. The latches change in the cycle after the chip-select fall is sampled and at no other time.
- R5: Mode 4 writes the 10 bits that precede the mode into `dimOut`, and the earliest of those bits becomes bit 0. No other mode changes `dimOut`.
- R6: Mode 5 produces a single-cycle `scanStop` pulse one cycle after the chip-select fall, and changes no latch.
- R7: Mode 6 or 7 arms a readout. At the next chip-select rise, `sdOe` goes high and `sdOut` presents the first snapshot bit. Each later rising `sclkIn` edge advances `sdOut` by one bit.
- R8: An ADC readout (mode 7) sends the 64 bits of `adcSnap` starting at bit 0. Channel k sits in `adcSnap[8k-1:8(k-1)]`, least significant bit first. After the last bit, `sdOut` is 0.
- R9: A switch readout (mode 6) sends the 37 bits of `swSnap` starting at bit 0. After the last bit, `sdOut` is 0.
- R10: The snapshot is frozen when the readout window opens. The chip-select fall that ends the readout window clears `sdOe` and returns the port to receiving. Clocks and data seen during a readout window never change a latch.
- R11: A rising `sclkIn` edge that arrives in the same cycle as the chip-select rise opening a readout window does not advance the output. The first bit stays on `sdOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip-select, high while a transfer window is open |
| sclkIn | input | 1 | Serial clock from the host |
| sdIn | input | 1 | Serial data from the host |
| sdOut | output | 1 | Serial data toward the host during a readout |
| sdOe | output | 1 | High while the port drives the data line |
| swSnap | input | 37 | Key-matrix and encoder snapshot, bit 0 sent first |
| adcSnap | input | 64 | Eight 8-bit ADC results, channel 1 in the low byte |
| segOut | output | 96 | Three 32-bit segment latches, grid 1 in the low word |
| dimOut | output | 10 | Dimming latch |
| scanStop | output | 1 | One-cycle pulse requesting a stop of key scanning |

## Verification
Two events can coincide in a single cycle: the chip-select edge that opens or closes a window, and a rising serial-clock edge. The bench provokes both cases. It raises chip-select and the serial clock in the same cycle to open an ADC readout, and it drops chip-select together with a final clock rise at the end of a dimming frame. For the readout, the check passes only if the full 64-bit word comes back with bit 0 first, which proves the coincident edge did not advance the output. For the dimming frame, the check passes only if `dimOut` holds the value sent before the extra edge, which proves the mode field was not shifted by one place.

// File: rtl/tri_wire_pkg.sv
package tri_wire_pkg;
  localparam int NUM_GRIDS = 3;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_DIM  = 3'd4;
  localparam logic [MODE_W-1:0] MODE_STOP = 3'd5;
  localparam logic [MODE_W-1:0] MODE_SW   = 3'd6;
  localparam logic [MODE_W-1:0] MODE_ADC  = 3'd7;

  typedef enum logic [1:0] {
    ST_RECV    = 2'd0,
    ST_ARM_SW  = 2'd1,
    ST_ARM_ADC = 2'd2,
    ST_SEND    = 2'd3
  } link_state_e;

  // Strobes from the control to the datapath, valid for one clock.
  typedef struct packed {
    logic                 rxClear;
    logic                 rxShift;
    logic [NUM_GRIDS-1:0] segLoad;
    logic                 dimLoad;
    logic                 swLoad;
    logic                 adcLoad;
    logic                 txShift;
  } strobe_t;

  // Mode 0 targets every grid, modes 1..NUM_GRIDS target one grid.
  function automatic logic [NUM_GRIDS-1:0] gridMask(input logic [MODE_W-1:0] mode);
    logic [NUM_GRIDS-1:0] mask;
    mask = '0;
    if (mode == '0) begin
      mask = '1;
    end else begin
      for (int g = 0; g < NUM_GRIDS; g++) begin
        if (int'(mode) == g + 1) mask[g] = 1'b1;
      end
    end
    return mask;
  endfunction
endpackage

// File: rtl/twp_edges.sv
module twp_edges (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic sclkIn,
  output logic csRise,
  output logic csFall,
  output logic sclkRise
);
  logic csD;
  logic sclkD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csD   <= 1'b0;
      sclkD <= 1'b0;
    end else begin
      csD   <= csIn;
      sclkD <= sclkIn;
    end
  end

  assign csRise   = csIn & ~csD;
  assign csFall   = ~csIn & csD;
  assign sclkRise = sclkIn & ~sclkD;
endmodule

// File: rtl/twp_ctrl.sv
module twp_ctrl
  import tri_wire_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              csRise,
  input  logic              csFall,
  input  logic              sclkRise,
  input  logic [MODE_W-1:0] modeBits,
  output strobe_t           stb,
  output logic              scanStop,
  output logic              txActive
);
  link_state_e state;
  link_state_e stateNext;
  logic [1:0]  rxCnt;
  logic        frameOk;
  logic        stopNext;

  // Only a window holding at least a full mode field is decoded.
  assign frameOk = (rxCnt == 2'd3);

  always_comb begin
    stb       = '0;
    stateNext = state;
    stopNext  = 1'b0;
    unique case (state)
      ST_RECV: begin
        if (csRise) begin
          stb.rxClear = 1'b1;
        end else if (csIn && sclkRise) begin
          stb.rxShift = 1'b1;
        end
        if (csFall && frameOk) begin
          stb.segLoad = gridMask(modeBits);
          stb.dimLoad = (modeBits == MODE_DIM);
          stopNext    = (modeBits == MODE_STOP);
          if (modeBits == MODE_SW) begin
            stateNext = ST_ARM_SW;
          end else if (modeBits == MODE_ADC) begin
            stateNext = ST_ARM_ADC;
          end
        end
      end
      ST_ARM_SW: begin
        if (csRise) begin
          stb.swLoad = 1'b1;
          stateNext  = ST_SEND;
        end
      end
      ST_ARM_ADC: begin
        if (csRise) begin
          stb.adcLoad = 1'b1;
          stateNext   = ST_SEND;
        end
      end
      ST_SEND: begin
        if (csFall) begin
          stateNext = ST_RECV;
        end else if (csIn && sclkRise && !csRise) begin
          stb.txShift = 1'b1;
        end
      end
      default: stateNext = ST_RECV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_RECV;
      rxCnt    <= 2'd0;
      scanStop <= 1'b0;
    end else begin
      state    <= stateNext;
      scanStop <= stopNext;
      if (stb.rxClear || csFall) begin
        rxCnt <= 2'd0;
      end else if (stb.rxShift && rxCnt != 2'd3) begin
        rxCnt <= rxCnt + 2'd1;
      end
    end
  end

  assign txActive = (state == ST_SEND);
endmodule

// File: rtl/twp_datapath.sv
module twp_datapath
  import tri_wire_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int DIM_W = 10,
  parameter int SW_W  = 37,
  parameter int ADC_W = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sdIn,
  input  strobe_t                    stb,
  input  logic [SW_W-1:0]            swSnap,
  input  logic [ADC_W-1:0]           adcSnap,
  output logic [MODE_W-1:0]          modeBits,
  output logic                       txBit,
  output logic [NUM_GRIDS*SEG_W-1:0] segOut,
  output logic [DIM_W-1:0]           dimOut
);
  localparam int RX_W = SEG_W + MODE_W;
  localparam int TX_W = (SW_W > ADC_W) ? SW_W : ADC_W;

  logic [RX_W-1:0]  rxReg;
  logic [TX_W-1:0]  txReg;
  logic [SEG_W-1:0] segPay;
  logic [DIM_W-1:0] dimPay;

  // New bits enter at the top; after a frame the mode sits highest,
  // with the payload just below it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg <= '0;
    end else if (stb.rxClear) begin
      rxReg <= '0;
    end else if (stb.rxShift) begin
      rxReg <= {sdIn, rxReg[RX_W-1:1]};
    end
  end

  assign modeBits = rxReg[RX_W-1 -: MODE_W];
  assign segPay   = rxReg[SEG_W-1:0];
  assign dimPay   = rxReg[SEG_W-1 -: DIM_W];

  for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_grid
    logic [SEG_W-1:0] segReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        segReg <= '0;
      end else if (stb.segLoad[g]) begin
        segReg <= segPay;
      end
    end
    assign segOut[g*SEG_W +: SEG_W] = segReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dimOut <= '0;
    end else if (stb.dimLoad) begin
      dimOut <= dimPay;
    end
  end

  // Snapshot load wins over shifting; zeros fill behind the last bit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (stb.swLoad) begin
      txReg <= TX_W'(swSnap);
    end else if (stb.adcLoad) begin
      txReg <= TX_W'(adcSnap);
    end else if (stb.txShift) begin
      txReg <= {1'b0, txReg[TX_W-1:1]};
    end
  end

  assign txBit = txReg[0];
endmodule

// File: rtl/tri_wire_port.sv
module tri_wire_port
  import tri_wire_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int DIM_W = 10,
  parameter int SW_W  = 37,
  parameter int ADC_W = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csIn,
  input  logic                       sclkIn,
  input  logic                       sdIn,
  output logic                       sdOut,
  output logic                       sdOe,
  input  logic [SW_W-1:0]            swSnap,
  input  logic [ADC_W-1:0]           adcSnap,
  output logic [NUM_GRIDS*SEG_W-1:0] segOut,
  output logic [DIM_W-1:0]           dimOut,
  output logic                       scanStop
);
  logic              csRiseEv;
  logic              csFallEv;
  logic              sclkRiseEv;
  logic [MODE_W-1:0] modeBits;
  logic              txBit;
  logic              txActive;
  strobe_t           stb;

  twp_edges u_edges (
    .clk      (clk),
    .rstN     (rstN),
    .csIn     (csIn),
    .sclkIn   (sclkIn),
    .csRise   (csRiseEv),
    .csFall   (csFallEv),
    .sclkRise (sclkRiseEv)
  );

  twp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csIn     (csIn),
    .csRise   (csRiseEv),
    .csFall   (csFallEv),
    .sclkRise (sclkRiseEv),
    .modeBits (modeBits),
    .stb      (stb),
    .scanStop (scanStop),
    .txActive (txActive)
  );

  twp_datapath #(
    .SEG_W (SEG_W),
    .DIM_W (DIM_W),
    .SW_W  (SW_W),
    .ADC_W (ADC_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .sdIn     (sdIn),
    .stb      (stb),
    .swSnap   (swSnap),
    .adcSnap  (adcSnap),
    .modeBits (modeBits),
    .txBit    (txBit),
    .segOut   (segOut),
    .dimOut   (dimOut)
  );

  assign sdOe  = txActive;
  assign sdOut = txActive & txBit;
endmodule

// File: rtl/twp_checker.sv
module twp_checker #(
  parameter int SEG_W = 32,
  parameter int DIM_W = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               csIn,
  input logic               sdOut,
  input logic               sdOe,
  input logic               scanStop,
  input logic [3*SEG_W-1:0] segOut,
  input logic [DIM_W-1:0]   dimOut,
  input logic               csFall,
  input logic               sclkRise
);
  // R6
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanStop |=> !scanStop);

  // R4
  seg_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(segOut) |-> $past(csFall));

  // R5
  dim_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dimOut) |-> $past(csFall));

  // R10
  send_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(sdOe) |-> ($stable(segOut) && $stable(dimOut)));

  // R7
  oe_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdOe) |-> csIn);

  // R10
  oe_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdOe) |-> $past(csFall));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdOe && $past(sdOe) && !$past(sclkRise)) |-> $stable(sdOut));
endmodule

bind tri_wire_port twp_checker #(
  .SEG_W (SEG_W),
  .DIM_W (DIM_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csIn     (csIn),
  .sdOut    (sdOut),
  .sdOe     (sdOe),
  .scanStop (scanStop),
  .segOut   (segOut),
  .dimOut   (dimOut),
  .csFall   (csFallEv),
  .sclkRise (sclkRiseEv)
);

// File: tb/test_tri_wire_port.sv
`timescale 1ns/1ps
module test_tri_wire_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cs = 1'b0;
  logic        sclk = 1'b0;
  logic        sd = 1'b0;
  logic [36:0] swSnap = '0;
  logic [63:0] adcSnap = '0;
  logic        sdOut;
  logic        sdOe;
  logic [95:0] segOut;
  logic [9:0]  dimOut;
  logic        scanStop;

  int checks = 0;
  int fails = 0;
  int stopSeen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tri_wire_port i_tri_wire_port (
    .clk      (clk),
    .rstN     (rstN),
    .csIn     (cs),
    .sclkIn   (sclk),
    .sdIn     (sd),
    .sdOut    (sdOut),
    .sdOe     (sdOe),
    .swSnap   (swSnap),
    .adcSnap  (adcSnap),
    .segOut   (segOut),
    .dimOut   (dimOut),
    .scanStop (scanStop)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mCsD, mSclkD;
  int          mState;          // 0 receive, 1 switch armed, 2 ADC armed, 3 sending
  bit          mBits[$];
  logic [95:0] mSeg;
  logic [9:0]  mDim;
  logic        mStop;
  logic [63:0] mTx;

  always @(posedge clk) begin
    if (!rstN) begin
      mCsD = 0; mSclkD = 0; mState = 0; mBits.delete();
      mSeg = '0; mDim = '0; mStop = 0; mTx = '0;
    end else begin
      bit csR, csF, sr;
      csR = cs && !mCsD;
      csF = !cs && mCsD;
      sr  = sclk && !mSclkD;
      mStop = 0;
      case (mState)
        0: begin
          if (csR) mBits.delete();
          else if (cs && sr) mBits.push_back(sd);
          if (csF) begin
            int n;
            n = mBits.size();
            if (n >= 3) begin
              int mode;
              logic [31:0] pay;
              logic [9:0]  dv;
              mode = mBits[n-3] + 2*mBits[n-2] + 4*mBits[n-1];
              pay = '0; dv = '0;
              for (int j = 0; j < 32; j++) if (n-35+j >= 0) pay[j] = mBits[n-35+j];
              for (int j = 0; j < 10; j++) if (n-13+j >= 0) dv[j] = mBits[n-13+j];
              case (mode)
                0: mSeg = {pay, pay, pay};
                1: mSeg[31:0] = pay;
                2: mSeg[63:32] = pay;
                3: mSeg[95:64] = pay;
                4: mDim = dv;
                5: mStop = 1;
                6: mState = 1;
                default: mState = 2;
              endcase
            end
            mBits.delete();
          end
        end
        1, 2: if (csR) begin
          mTx = (mState == 1) ? {27'b0, swSnap} : adcSnap;
          mState = 3;
        end
        default: begin
          if (csF) mState = 0;
          else if (cs && sr) mTx = mTx >> 1;
        end
      endcase
      mCsD = cs;
      mSclkD = sclk;
    end
  end

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R4", segOut, mSeg, "model segments");
      chk("R5", dimOut, mDim, "model dimming");
      chk("R6", scanStop, mStop, "model stop pulse");
      chk("R10", sdOe, mState == 3, "model output enable");
      chk("R7", sdOut, (mState == 3) ? mTx[0] : 1'b0, "model serial out");
      if (scanStop) stopSeen++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBits(input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sd = v[i]; tick(1); sclk = 1; tick(2); sclk = 0; tick(1);
    end
  endtask

  task automatic sendFrame(input logic [63:0] v, input int n);
    tick(1); cs = 1; tick(2);
    clockBits(v, n);
    cs = 0; tick(3);
  endtask

  task automatic readWin(input int n, input bit scramble, input bit coincide,
                         output logic [63:0] got);
    string rq;
    rq = (n == 37) ? "R9" : "R8";
    got = '0;
    tick(1); cs = 1; if (coincide) sclk = 1; tick(2);
    chk("R7", sdOe, 1, "enable at window open");
    got[0] = sdOut;
    if (coincide) begin sclk = 0; tick(1); end
    if (scramble) adcSnap = ~adcSnap;
    sd = 1;
    for (int i = 1; i < n; i++) begin
      sclk = 1; tick(1); got[i] = sdOut; tick(1); sclk = 0; tick(1);
    end
    sclk = 1; tick(1);
    chk(rq, sdOut, 0, "zero after last bit");
    tick(1); sclk = 0; tick(1);
    sd = 0; cs = 0; tick(2);
    chk("R10", sdOe, 0, "enable released at window close");
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    logic [63:0] got;
    logic [63:0] adcRef;
    logic [95:0] segHold;
    logic [9:0]  dimHold;
    int          stops;

    tick(5); rstN = 1; tick(2);

    chk("R1", segOut, 96'h0, "segments after reset");
    chk("R1", dimOut, 10'h0, "dimming after reset");
    chk("R1", {sdOe, sdOut, scanStop}, 3'b000, "outputs after reset");

    sendFrame({29'h0, 3'd0, 32'hA5C3_0F96}, 35);
    chk("R4", segOut, {3{32'hA5C3_0F96}}, "mode 0 writes all grids");

    sendFrame({29'h0, 3'd2, 32'h1234_5678}, 35);
    chk("R4", segOut, {32'hA5C3_0F96, 32'h1234_5678, 32'hA5C3_0F96}, "mode 2 writes grid 2 only");

    sendFrame({51'h0, 3'd4, 10'h2D7}, 13);
    chk("R5", dimOut, 10'h2D7, "mode 4 dimming value");

    segHold = segOut; dimHold = dimOut;
    sendFrame(64'h1, 2);
    chk("R3", {segOut, dimOut}, {segHold, dimHold}, "two-bit window ignored");

    sendFrame({51'h0, 3'd3, 10'h3A5}, 13);
    chk("R3", segOut[95:64], {10'h3A5, 22'h0}, "short frame payload below mode");
    chk("R5", dimOut, 10'h2D7, "segment mode leaves dimming");

    sd = 1;
    for (int i = 0; i < 4; i++) begin sclk = 1; tick(2); sclk = 0; tick(2); end
    sendFrame({29'h0, 3'd1, 32'h0F0F_00FF}, 35);
    chk("R2", segOut[31:0], 32'h0F0F_00FF, "clocks outside window ignored");

    segHold = segOut; stops = stopSeen;
    sendFrame({61'h0, 3'd5}, 3);
    chk("R6", stopSeen - stops, 1, "one stop pulse");
    chk("R6", segOut, segHold, "stop mode leaves segments");

    swSnap = 37'h1A_5A5A_C3C3;
    sendFrame({61'h0, 3'd6}, 3);
    readWin(37, 0, 0, got);
    chk("R9", got, {27'h0, 37'h1A_5A5A_C3C3}, "switch readout word");
    chk("R10", {segOut, dimOut}, {segHold, 10'h2D7}, "readout clocks leave latches");

    adcSnap = 64'h8877_6655_4433_2211; adcRef = adcSnap;
    sendFrame({61'h0, 3'd7}, 3);
    readWin(64, 1, 0, got);
    chk("R8", got, adcRef, "ADC readout channel order");
    chk("R10", got, adcRef, "snapshot frozen at window open");

    sendFrame({51'h0, 3'd4, 10'h155}, 13);
    chk("R10", dimOut, 10'h155, "receiving resumes after readout");

    adcSnap = 64'hF00D_1234_BEEF_C0DE; adcRef = adcSnap;
    sendFrame({61'h0, 3'd7}, 3);
    readWin(64, 0, 1, got);
    chk("R11", got, adcRef, "coincident clock at window open");

    tick(1); cs = 1; tick(2);
    clockBits({51'h0, 3'd4, 10'h0C3}, 13);
    sd = 1; sclk = 1; cs = 0; tick(1); sclk = 0; tick(3);
    chk("R2", dimOut, 10'h0C3, "clock at window close ignored");

    tick(5);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL all requirements: watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule